// File: doc/BRIEF.md
# Mode 0 Serial Peripheral Byte Master

This block runs one 8-bit full-duplex exchange on a four-wire serial peripheral bus in mode 0. A one-cycle start request carries the byte to send. The block pulls the active-low select line down and shifts the byte out on the data-out pin, most significant bit first. It builds the serial clock from the system clock with a parameterised divider, and it collects eight bits from the data-in pin at the same time.

The serial clock idles low. Data-in is captured on each rising serial-clock edge, and data-out moves only on falling edges. The select line stays low for the whole byte. The clock is brought back low for a full half period before select is released. When select goes high, the received byte is presented together with a one-cycle done pulse. A start request that arrives while a transfer is under way is dropped. The select line then stays high for at least one half period before the next transfer can begin.

Top module: `spi_byte_master`

## Requirements
- R1: While reset is applied and right after it is released, sel_n_o is 1, sclk_o is 0, done_o is 0 and rx_byte_o is 8'h00.
- R2: A start_i seen in the idle state drives sel_n_o low at the next clock edge. At that point sclk_o is still 0 and mosi_o already carries bit 7 of tx_byte_i.
- R3: Whenever sel_n_o is high, sclk_o is low.
- R4: Each high phase of sclk_o lasts HALF_DIV system clocks, so the serial clock period is 2*HALF_DIV clocks. A transfer has exactly eight rising sclk_o edges, and sel_n_o stays low for exactly 17*HALF_DIV clocks.
- R5: miso_i is sampled at each rising edge of sclk_o. The first sample becomes bit 7 of rx_byte_o and the last sample becomes bit 0.
- R6: mosi_o presents the transmit byte most significant bit first, and it changes only at a clock edge where sclk_o falls while sel_n_o stays low.
- R7: sel_n_o rises only in the cycle in which done_o is asserted, and sclk_o has been low in the cycle before.
- R8: done_o is high for exactly one clock per transfer. rx_byte_o is updated when done_o rises and holds its value until the next done_o.
- R9: start_i has no effect unless the block is idle. A start request during a transfer changes neither the received byte nor the length of the transfer, and it does not start a second transfer.
- R10: With start_i held high, sel_n_o stays high for exactly HALF_DIV+1 clocks between two back-to-back transfers.
- R11: With mosi_o tied back to miso_i, rx_byte_o equals the byte that was sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Transfer request, sampled only when idle |
| tx_byte_i | input | 8 | Byte to send, captured with an accepted start |
| miso_i | input | 1 | Serial data from the peripheral |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the peripheral |
| sel_n_o | output | 1 | Active-low peripheral select |
| rx_byte_o | output | 8 | Byte received in the last transfer |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The embedded assertions check the cycle-local protocol rules on every cycle: the serial clock is low whenever select is high, data-out moves only on falling edges, select rises together with done and after a low clock phase, done lasts one cycle, and an idle start pulls select low. Some properties span a whole transfer and can only be shown by the bench scenarios. These are the half-period length, the count of eight rising edges, the order of the received bits from a scripted peripheral, loopback integrity, the dropping of a start request in mid-transfer, and the exact select-high gap between back-to-back transfers.

// File: rtl/spi_m0_pkg.sv
package spi_m0_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_half_tick.sv
// Counts system clocks while enabled and emits a tick every HALF_DIV clocks.
module spi_half_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i && wrap;
endmodule

// File: rtl/spi_seq.sv
// Transfer sequencer: owns the select line, the serial clock and the edge count.
module spi_seq
  import spi_m0_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic sel_n_o,
  output logic sclk_o,
  output logic load_o,
  output logic sample_o,
  output logic shift_o,
  output logic fin_o,
  output logic done_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES + 2);
  localparam logic [EW-1:0] LAST_TOG = EW'(EDGES - 1);
  localparam logic [EW-1:0] HOLD_END = EW'(EDGES);
  localparam logic [EW-1:0] TAIL     = EW'(EDGES + 1);

  xfer_state_e st_q, st_d;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic          sclk_q, sclk_d;
  logic          done_q;

  always_comb begin
    st_d     = st_q;
    ecnt_d   = ecnt_q;
    sclk_d   = sclk_q;
    load_o   = 1'b0;
    sample_o = 1'b0;
    shift_o  = 1'b0;
    fin_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        ecnt_d = '0;
        sclk_d = 1'b0;
        if (start_i) begin
          st_d   = ST_XFER;
          load_o = 1'b1;
        end
      end
      ST_XFER: begin
        if (tick_i) begin
          sclk_d = !sclk_q;
          ecnt_d = ecnt_q + 1'b1;
          if (!sclk_q) begin
            sample_o = 1'b1;
          end else if (ecnt_q != LAST_TOG) begin
            shift_o = 1'b1;
          end
          if (ecnt_q == LAST_TOG) begin
            st_d = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        sclk_d = 1'b0;
        if (tick_i) begin
          if (ecnt_q == HOLD_END) begin
            ecnt_d = TAIL;
            fin_o  = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: begin
        st_d   = ST_IDLE;
        sclk_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ecnt_q <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ecnt_q <= ecnt_d;
      sclk_q <= sclk_d;
      done_q <= fin_o;
    end
  end

  assign run_o   = (st_q != ST_IDLE);
  assign sel_n_o = (st_q == ST_IDLE) || ((st_q == ST_DONE) && (ecnt_q == TAIL));
  assign sclk_o  = sclk_q;
  assign done_o  = done_q;

  assert_sel_high_clock_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_o |-> !sclk_o);

  assert_idle_start_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i) |=> !sel_n_o);

  assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_release_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n_o) |-> done_o);

  assert_release_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n_o) |-> !$past(sclk_o));
endmodule

// File: rtl/spi_shreg.sv
// Transmit and receive shift registers plus the presented receive byte.
module spi_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              miso_i,
  input  logic              fin_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i) begin
      tx_d = tx_i;
    end else if (shift_i) begin
      tx_d = {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_comb begin
    sh_d = sh_q;
    if (sample_i) begin
      sh_d = {sh_q[DATA_W-2:0], miso_i};
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (fin_i) begin
      rx_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      sh_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      sh_q <= sh_d;
      rx_q <= rx_d;
    end
  end

  assign mosi_o = tx_q[DATA_W-1];
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int HALF_DIV = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              sel_n_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              done_o
);
  logic [1:0] rsync_q;
  logic       rst_n_int;
  logic       run, tick, load, sample, shift, fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rsync_q[1];

  spi_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_seq #(.DATA_W(DATA_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start_i),
    .tick_i   (tick),
    .run_o    (run),
    .sel_n_o  (sel_n_o),
    .sclk_o   (sclk_o),
    .load_o   (load),
    .sample_o (sample),
    .shift_o  (shift),
    .fin_o    (fin),
    .done_o   (done_o)
  );

  spi_shreg #(.DATA_W(DATA_W)) i_shreg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_i   (load),
    .tx_i     (tx_byte_i),
    .sample_i (sample),
    .shift_i  (shift),
    .miso_i   (miso_i),
    .fin_i    (fin),
    .mosi_o   (mosi_o),
    .rx_o     (rx_byte_o)
  );

  // Data-out may only move at a falling serial-clock edge inside a transfer.
  assert_mosi_moves_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!sel_n_o && !$past(sel_n_o) && (mosi_o != $past(mosi_o))) |-> $fell(sclk_o));
endmodule

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sclk, mosi, sel_n, done;
  logic [7:0] rx_byte;
  logic       loopback = 1'b0;
  logic [7:0] slave_byte = 8'h00;
  logic [7:0] slave_sr = 8'h00;
  logic       slave_prev_sclk = 1'b0;
  logic       miso;

  int n_chk = 0;
  int n_fail = 0;

  // meas
  int cs_cnt, hi_cnt, rise_cnt, bad_mosi, hi_run, hi_bad;
  logic [7:0] mosi_seen;

  always #5 clk = ~clk;

  assign miso = loopback ? mosi : slave_sr[7];

  // Scripted peripheral: loads while deselected, shifts after each falling clock edge.
  always @(negedge clk) begin
    if (sel_n) begin
      slave_sr = slave_byte;
    end else if (slave_prev_sclk && !sclk) begin
      slave_sr = {slave_sr[6:0], 1'b0};
    end
    slave_prev_sclk = sclk;
  end

  spi_byte_master #(.HALF_DIV(D), .DATA_W(8)) i_spi_byte_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .tx_byte_i (tx_byte),
    .miso_i    (miso),
    .sclk_o    (sclk),
    .mosi_o    (mosi),
    .sel_n_o   (sel_n),
    .rx_byte_o (rx_byte),
    .done_o    (done)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Runs one transfer; start is presented at the current negedge.
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input logic lp, input logic mid);
    logic prev_sclk;
    logic prev_mosi;
    int   guard;
    loopback   = lp;
    slave_byte = sb;
    tx_byte    = tx;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_eq("R2 sel low after start", {31'd0, sel_n}, 32'd0);
    check_eq("R2 first mosi bit", {31'd0, mosi}, {31'd0, tx[7]});
    cs_cnt = 0; hi_cnt = 0; rise_cnt = 0; bad_mosi = 0; hi_run = 0; hi_bad = 0;
    mosi_seen = 8'h00;
    prev_sclk = 1'b0;
    prev_mosi = mosi;
    guard = 0;
    while (!sel_n && guard < 2000) begin
      cs_cnt++;
      if (sclk) begin
        hi_cnt++;
        hi_run++;
      end else begin
        if (prev_sclk && hi_run != D) hi_bad++;
        hi_run = 0;
      end
      if (sclk && !prev_sclk) begin
        rise_cnt++;
        mosi_seen = {mosi_seen[6:0], mosi};
      end
      if (mosi != prev_mosi && !(prev_sclk && !sclk)) bad_mosi++;
      prev_sclk = sclk;
      prev_mosi = mosi;
      if (mid && cs_cnt == 10) begin
        start   = 1'b1;
        tx_byte = ~tx;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check_eq("R4 sel low length", cs_cnt, 17 * D);
    check_eq("R4 rising edge count", rise_cnt, 8);
    check_eq("R4 high phase lengths", hi_bad, 0);
    check_eq("R6 mosi change off falling edge", bad_mosi, 0);
    check_eq("R6 mosi order", {24'd0, mosi_seen}, {24'd0, tx});
    check_eq("R7 done with release", {31'd0, done}, 32'd1);
    check_eq("R3 clock low after release", {31'd0, sclk}, 32'd0);
    if (lp) check_eq("R11 loopback byte", {24'd0, rx_byte}, {24'd0, tx});
    else    check_eq("R5 received byte", {24'd0, rx_byte}, {24'd0, sb});
    @(negedge clk);
    check_eq("R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  // {tx, peripheral byte, loopback}
  localparam logic [16:0] VECS [0:7] = '{
    {8'h41, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1},
    {8'hFF, 8'h00, 1'b1},
    {8'hA5, 8'h3C, 1'b0},
    {8'h80, 8'h01, 1'b0},
    {8'h01, 8'h80, 1'b0},
    {8'h5A, 8'hC3, 1'b0},
    {8'hFF, 8'h00, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 actual=no-finish expected=finish");
    finish_run();
  end

  initial begin
    int gap;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check_eq("R1 sel in reset", {31'd0, sel_n}, 32'd1);
    check_eq("R1 sclk in reset", {31'd0, sclk}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 sel after reset", {31'd0, sel_n}, 32'd1);
    check_eq("R1 sclk after reset", {31'd0, sclk}, 32'd0);
    check_eq("R1 done after reset", {31'd0, done}, 32'd0);
    check_eq("R1 rx after reset", {24'd0, rx_byte}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      xfer(VECS[i][16:9], VECS[i][8:1], VECS[i][0], 1'b0);
      repeat (D + 2) @(negedge clk);
    end

    // R8: received byte holds while idle
    held = rx_byte;
    repeat (10) @(negedge clk);
    check_eq("R8 rx held", {24'd0, rx_byte}, {24'd0, held});

    // R9: start during a transfer is dropped
    xfer(8'h3C, 8'h96, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check_eq("R9 no second transfer", {31'd0, sel_n}, 32'd1);
    check_eq("R9 rx unchanged by mid start", {24'd0, rx_byte}, 32'h96);

    // R10: back-to-back transfers with start held
    loopback = 1'b1;
    tx_byte  = 8'h96;
    start    = 1'b1;
    gap = 0;
    for (int g = 0; g < 1000 && !done; g++) @(negedge clk);
    for (int g = 0; g < 1000 && sel_n; g++) begin
      gap++;
      @(negedge clk);
    end
    start = 1'b0;
    check_eq("R10 select gap", gap, D + 1);
    for (int g = 0; g < 1000 && !done; g++) @(negedge clk);
    check_eq("R11 second loopback byte", {24'd0, rx_byte}, 32'h96);

    finish_run();
  end
endmodule